// File: doc/BRIEF.md
# Isochronous IN Endpoint Transmitter

This block is the transmit half of a device-side USB endpoint configured for isochronous IN traffic. Software fills a one-packet byte buffer and then raises a ready bit in a small control/status register. When the protocol engine reports an IN token, the block streams the buffered bytes out one per clock, in the order they were loaded, with a last-byte marker. Because isochronous traffic has no handshake, the packet counts as delivered once its final byte has left, and a completion flag is raised at that point.

If a token arrives and no packet has been handed over, the block asks the engine for a zero-length packet instead and records a sticky underrun, so software can see that it is not keeping pace with the host. If software finds the ready bit still set when it wants to load the next frame's packet, that packet was never taken. A self-clearing flush command discards it. A level interrupt reflects the completion flag when interrupts are enabled.

Top module: `iso_in_tx`

## Requirements
- R1: After reset the status register reads 0, no byte or zero-length request is output, and the interrupt is low.
- R2: A byte load appends to the buffer in order while bit 0 (ready) reads 0 and no stream is active. It is ignored while ready is 1 or once DEPTH bytes are held.
- R3: A token with ready = 1 and n > 0 bytes held makes tx_valid_o high for n consecutive cycles, starting the cycle after the token. The bytes come out in load order and tx_last_o marks the n-th. Tokens during a stream are ignored.
- R4: In the cycle after the last byte, ready reads 0, bit 1 (done) reads 1 and the buffer is empty.
- R5: A token with ready = 0 gives a one-cycle tx_zlp_o in the next cycle with no tx_valid_o, and sets bit 2 (underrun).
- R6: Underrun stays set through later zero-length replies and through writes with bit 2 = 1. Only a write with bit 2 = 0 clears it, and a new underrun in the same cycle wins.
- R7: Writing 1 to bit 0 sets ready. Writing 0 does not clear it, so a packet that was not sent stays visible as ready = 1 until it is sent or flushed.
- R8: Writing 1 to bit 3 (flush) clears ready, empties the buffer and aborts any stream. Bit 3 always reads 0. A token in the same cycle as a flush is answered as if the buffer were empty.
- R9: Bit 4 is the interrupt enable, and irq_o is high exactly when done and the enable are both 1. A write with bit 1 = 0 clears done, but a completion in the same cycle wins.
- R10: A token with ready = 1 and an empty buffer gives a zero-length request and a completion (ready 0, done 1) without setting underrun.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ld_en_i | input | 1 | Buffer byte load strobe |
| ld_data_i | input | 8 | Byte to load |
| csr_we_i | input | 1 | Status register write strobe |
| csr_wdata_i | input | 8 | Status register write data |
| csr_rdata_o | output | 8 | Status register read value |
| tok_i | input | 1 | IN token strobe from the protocol engine |
| tx_valid_o | output | 1 | Packet byte valid |
| tx_data_o | output | 8 | Packet byte |
| tx_last_o | output | 1 | Final byte of the packet |
| tx_zlp_o | output | 1 | Send a zero-length packet |
| irq_o | output | 1 | Completion interrupt (level) |

## Verification
A wrong stream index or fill count shows on tx_data_o or tx_last_o within the same packet, one cycle after the token at the earliest. A stale ready or done bit appears on csr_rdata_o and irq_o in the cycle after the completion or flush that should have changed it. A lost or spurious underrun shows in bit 2 one cycle after the token. Because the model is compared every clock, the first diverging cycle is reported.

// File: rtl/iso_in_pkg.sv
package iso_in_pkg;
    localparam int B_RDY   = 0;
    localparam int B_DONE  = 1;
    localparam int B_UNDER = 2;
    localparam int B_FLUSH = 3;
    localparam int B_IEN   = 4;
    localparam int CSR_W   = 8;
    localparam int BYTE_W  = 8;
endpackage

// File: rtl/iso_tx_buf.sv
module iso_tx_buf #(
    parameter int DEPTH = 64,
    parameter int DW    = 8
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       ld_i,
    input  logic [DW-1:0]              ld_data_i,
    input  logic                       clr_i,
    input  logic [$clog2(DEPTH)-1:0]   rd_idx_i,
    output logic [DW-1:0]              rd_data_o,
    output logic [$clog2(DEPTH+1)-1:0] fill_o
);
    localparam int IDX_W = $clog2(DEPTH);
    localparam int CNT_W = $clog2(DEPTH + 1);

    logic [DW-1:0]    mem [DEPTH];
    logic [CNT_W-1:0] fill_d, fill_q;
    logic             wr_ok;

    always_comb begin
        wr_ok  = ld_i && (fill_q < CNT_W'(DEPTH)) && !clr_i;
        fill_d = fill_q;
        if (clr_i)      fill_d = '0;
        else if (wr_ok) fill_d = fill_q + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) fill_q <= '0;
        else        fill_q <= fill_d;
    end

    always_ff @(posedge clk) begin
        if (wr_ok) mem[IDX_W'(fill_q)] <= ld_data_i;
    end

    assign rd_data_o = mem[rd_idx_i];
    assign fill_o    = fill_q;

    p_fill_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
        fill_q <= CNT_W'(DEPTH));
    p_clear_empty_r8: assert property (@(posedge clk) disable iff (!rst_n)
        clr_i |=> fill_q == '0);
endmodule

// File: rtl/iso_tx_ctrl.sv
module iso_tx_ctrl
    import iso_in_pkg::*;
#(
    parameter int DEPTH = 64
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       tok_i,
    input  logic                       csr_we_i,
    input  logic [CSR_W-1:0]           csr_wdata_i,
    input  logic [$clog2(DEPTH+1)-1:0] fill_i,
    output logic [$clog2(DEPTH)-1:0]   rd_idx_o,
    output logic                       buf_clr_o,
    output logic                       load_ok_o,
    output logic                       tx_valid_o,
    output logic                       tx_last_o,
    output logic                       tx_zlp_o,
    output logic [CSR_W-1:0]           csr_rdata_o,
    output logic                       irq_o
);
    localparam int IDX_W = $clog2(DEPTH);
    localparam int CNT_W = $clog2(DEPTH + 1);

    typedef struct packed {
        logic             sending;
        logic [IDX_W-1:0] idx;
        logic             rdy;
        logic             done;
        logic             under;
        logic             ien;
        logic             zlp;
    } st_t;

    st_t  d, q;
    logic flush;
    logic at_last;

    always_comb begin
        d         = q;
        d.zlp     = 1'b0;
        buf_clr_o = 1'b0;
        flush     = csr_we_i && csr_wdata_i[B_FLUSH];
        at_last   = CNT_W'(q.idx) == (fill_i - 1'b1);

        if (csr_we_i) begin
            if (csr_wdata_i[B_RDY])    d.rdy   = 1'b1;
            if (!csr_wdata_i[B_DONE])  d.done  = 1'b0;
            if (!csr_wdata_i[B_UNDER]) d.under = 1'b0;
            d.ien = csr_wdata_i[B_IEN];
        end

        if (q.sending) begin
            if (flush) begin
                d.sending = 1'b0;
                d.idx     = '0;
                d.rdy     = 1'b0;
                buf_clr_o = 1'b1;
            end else if (at_last) begin
                d.sending = 1'b0;
                d.idx     = '0;
                d.rdy     = 1'b0;
                d.done    = 1'b1;
                buf_clr_o = 1'b1;
            end else begin
                d.idx = q.idx + 1'b1;
            end
        end else begin
            if (flush) begin
                d.rdy     = 1'b0;
                buf_clr_o = 1'b1;
            end
            if (tok_i) begin
                if (q.rdy && !flush && fill_i != '0) begin
                    d.sending = 1'b1;
                    d.idx     = '0;
                end else if (q.rdy && !flush) begin
                    d.zlp     = 1'b1;
                    d.rdy     = 1'b0;
                    d.done    = 1'b1;
                    buf_clr_o = 1'b1;
                end else begin
                    d.zlp   = 1'b1;
                    d.under = 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    always_comb begin
        csr_rdata_o          = '0;
        csr_rdata_o[B_RDY]   = q.rdy;
        csr_rdata_o[B_DONE]  = q.done;
        csr_rdata_o[B_UNDER] = q.under;
        csr_rdata_o[B_IEN]   = q.ien;
    end

    assign rd_idx_o   = q.idx;
    assign load_ok_o  = !q.rdy && !q.sending;
    assign tx_valid_o = q.sending;
    assign tx_last_o  = q.sending && at_last;
    assign tx_zlp_o   = q.zlp;
    assign irq_o      = q.done && q.ien;

    p_empty_tok_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (tok_i && !tx_valid_o && !csr_rdata_o[B_RDY]) |=> (tx_zlp_o && csr_rdata_o[B_UNDER]));
    p_zlp_excl_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !(tx_valid_o && tx_zlp_o));
    p_stream_cont_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_valid_o && !tx_last_o && !flush) |=> tx_valid_o);
    p_complete_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_last_o && !flush) |=> (!csr_rdata_o[B_RDY] && csr_rdata_o[B_DONE] && !tx_valid_o));
    p_under_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (csr_rdata_o[B_UNDER] && !(csr_we_i && !csr_wdata_i[B_UNDER])) |=> csr_rdata_o[B_UNDER]);
    p_rdy_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (csr_rdata_o[B_RDY] && !tx_valid_o && !tok_i && !flush) |=> csr_rdata_o[B_RDY]);
    p_flush_r8: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (!csr_rdata_o[B_RDY] && !tx_valid_o && fill_i == '0));
endmodule

// File: rtl/iso_in_tx.sv
module iso_in_tx
    import iso_in_pkg::*;
#(
    parameter int DEPTH = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ld_en_i,
    input  logic [BYTE_W-1:0] ld_data_i,
    input  logic              csr_we_i,
    input  logic [CSR_W-1:0]  csr_wdata_i,
    output logic [CSR_W-1:0]  csr_rdata_o,
    input  logic              tok_i,
    output logic              tx_valid_o,
    output logic [BYTE_W-1:0] tx_data_o,
    output logic              tx_last_o,
    output logic              tx_zlp_o,
    output logic              irq_o
);
    localparam int IDX_W = $clog2(DEPTH);
    localparam int CNT_W = $clog2(DEPTH + 1);

    logic [IDX_W-1:0] rd_idx;
    logic [CNT_W-1:0] fill;
    logic             buf_clr;
    logic             load_ok;

    iso_tx_buf #(.DEPTH(DEPTH), .DW(BYTE_W)) i_buf (
        .clk       (clk),
        .rst_n     (rst_n),
        .ld_i      (ld_en_i && load_ok),
        .ld_data_i (ld_data_i),
        .clr_i     (buf_clr),
        .rd_idx_i  (rd_idx),
        .rd_data_o (tx_data_o),
        .fill_o    (fill)
    );

    iso_tx_ctrl #(.DEPTH(DEPTH)) i_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .tok_i       (tok_i),
        .csr_we_i    (csr_we_i),
        .csr_wdata_i (csr_wdata_i),
        .fill_i      (fill),
        .rd_idx_o    (rd_idx),
        .buf_clr_o   (buf_clr),
        .load_ok_o   (load_ok),
        .tx_valid_o  (tx_valid_o),
        .tx_last_o   (tx_last_o),
        .tx_zlp_o    (tx_zlp_o),
        .csr_rdata_o (csr_rdata_o),
        .irq_o       (irq_o)
    );
endmodule

// File: tb/test_iso_in_tx.sv
`timescale 1ns/1ps
module test_iso_in_tx;
    localparam int DEPTH = 8;

    logic       clk = 0;
    logic       rst_n = 0;
    logic       ld_en = 0;
    logic [7:0] ld_data = 0;
    logic       csr_we = 0;
    logic [7:0] csr_wdata = 0;
    logic [7:0] csr_rdata;
    logic       tok = 0;
    logic       tx_valid, tx_last, tx_zlp, irq;
    logic [7:0] tx_data;

    int checks = 0;
    int fails  = 0;
    string cur_req = "R1";
    bit finished = 0;

    always #4 clk = ~clk;

    iso_in_tx #(.DEPTH(DEPTH)) i_iso_in_tx (
        .clk(clk), .rst_n(rst_n), .ld_en_i(ld_en), .ld_data_i(ld_data),
        .csr_we_i(csr_we), .csr_wdata_i(csr_wdata), .csr_rdata_o(csr_rdata),
        .tok_i(tok), .tx_valid_o(tx_valid), .tx_data_o(tx_data),
        .tx_last_o(tx_last), .tx_zlp_o(tx_zlp), .irq_o(irq)
    );

    // behavioural reference model
    byte unsigned mq[$];
    bit m_send = 0, m_rdy = 0, m_done = 0, m_under = 0, m_ien = 0, m_zlp = 0;
    int m_pos = 0;

    always @(posedge clk) begin
        int  n;
        bit  fl, ordy;
        if (!rst_n) begin
            mq.delete();
            m_send = 0; m_rdy = 0; m_done = 0; m_under = 0; m_ien = 0; m_zlp = 0; m_pos = 0;
        end else begin
            n = mq.size();
            fl = csr_we && csr_wdata[3];
            ordy = m_rdy;
            m_zlp = 0;
            if (ld_en && !m_rdy && !m_send && n < DEPTH && !fl) mq.push_back(ld_data);
            if (csr_we) begin
                if (csr_wdata[0])  m_rdy = 1;
                if (!csr_wdata[1]) m_done = 0;
                if (!csr_wdata[2]) m_under = 0;
                m_ien = csr_wdata[4];
            end
            if (m_send) begin
                if (fl) begin m_send = 0; m_rdy = 0; m_pos = 0; mq.delete(); end
                else if (m_pos == n - 1) begin
                    m_send = 0; m_rdy = 0; m_done = 1; m_pos = 0; mq.delete();
                end else m_pos++;
            end else begin
                if (fl) begin m_rdy = 0; mq.delete(); end
                if (tok) begin
                    if (ordy && !fl && n > 0) begin m_send = 1; m_pos = 0; end
                    else if (ordy && !fl) begin m_zlp = 1; m_rdy = 0; m_done = 1; mq.delete(); end
                    else begin m_zlp = 1; m_under = 1; end
                end
            end
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // per-cycle comparison against the model
    always @(negedge clk) begin
        if (rst_n) begin
            logic [7:0] er;
            bit el;
            er = {3'b0, m_ien, 1'b0, m_under, m_done, m_rdy};
            el = m_send && (m_pos == mq.size() - 1);
            chk(tx_valid == m_send, {cur_req, " valid"}, tx_valid, m_send);
            chk(tx_last == el, {cur_req, " last"}, tx_last, el);
            chk(tx_zlp == m_zlp, {cur_req, " zlp"}, tx_zlp, m_zlp);
            chk(csr_rdata == er, {cur_req, " csr"}, csr_rdata, er);
            chk(irq == (m_done && m_ien), {cur_req, " irq"}, irq, m_done && m_ien);
            if (m_send) chk(tx_data == mq[m_pos], {cur_req, " data"}, tx_data, mq[m_pos]);
        end
    end

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask
    task automatic load(input byte unsigned b);
        ld_en = 1; ld_data = b; @(negedge clk); ld_en = 0;
    endtask
    task automatic wcsr(input logic [7:0] v);
        csr_we = 1; csr_wdata = v; @(negedge clk); csr_we = 0;
    endtask
    task automatic token();
        tok = 1; @(negedge clk); tok = 0;
    endtask
    task automatic collect(output byte unsigned got[$]);
        int g;
        got.delete(); g = 0;
        while (tx_valid && g < 100) begin
            got.push_back(tx_data); g++;
            @(negedge clk);
        end
    endtask

    initial begin
        #(8 * 200000);
        if (!finished) begin
            fails++;
            $display("FAIL watchdog actual=0 expected=1");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        byte unsigned got[$];
        idle(3);
        rst_n = 1;
        @(negedge clk);
        // R1 reset state
        cur_req = "R1";
        chk(csr_rdata == 8'h00, "R1 csr", csr_rdata, 0);
        chk(!tx_valid && !tx_zlp && !irq, "R1 outputs", {tx_valid, tx_zlp, irq}, 0);

        // R5 empty-buffer token
        cur_req = "R5";
        token();
        chk(tx_zlp == 1 && tx_valid == 0, "R5 zlp", {tx_valid, tx_zlp}, 1);
        chk(csr_rdata[2] == 1, "R5 underrun", csr_rdata, 4);
        idle(1);
        chk(tx_zlp == 0, "R5 one cycle", tx_zlp, 0);

        // R6 sticky underrun
        cur_req = "R6";
        wcsr(8'h04);
        chk(csr_rdata[2] == 1, "R6 write1 keeps", csr_rdata, 4);
        token();
        chk(csr_rdata[2] == 1, "R6 later zlp keeps", csr_rdata, 4);
        wcsr(8'h00);
        chk(csr_rdata[2] == 0, "R6 write0 clears", csr_rdata, 0);
        csr_we = 1; csr_wdata = 8'h00; tok = 1; @(negedge clk); csr_we = 0; tok = 0;
        chk(csr_rdata[2] == 1, "R6 set wins", csr_rdata, 4);
        wcsr(8'h00);

        // R2 R3 R4 R9 normal packet
        cur_req = "R3";
        wcsr(8'h10);
        for (int i = 0; i < 5; i++) load(8'hA0 + i);
        wcsr(8'h11);
        load(8'h55); // R2: ignored while ready
        tok = 1; @(negedge clk); tok = 0;
        tok = 1; // R3: token during stream ignored
        collect(got);
        tok = 0;
        chk(got.size() == 5, "R3 length", got.size(), 5);
        for (int i = 0; i < got.size(); i++) chk(got[i] == 8'hA0 + i, "R2 order", got[i], 8'hA0 + i);
        cur_req = "R4";
        chk(csr_rdata[1:0] == 2'b10, "R4 done/ready", csr_rdata[1:0], 2);
        chk(irq == 1, "R9 irq high", irq, 1);
        cur_req = "R9";
        wcsr(8'h10);
        chk(irq == 0, "R9 done cleared", irq, 0);
        wcsr(8'h02);
        idle(1);

        // R7 stale ready stays visible
        cur_req = "R7";
        for (int i = 0; i < 3; i++) load(8'h30 + i);
        wcsr(8'h01);
        wcsr(8'h00);
        chk(csr_rdata[0] == 1, "R7 write0 keeps", csr_rdata, 1);
        load(8'h77);
        idle(2);
        chk(csr_rdata[0] == 1, "R7 stale ready", csr_rdata, 1);

        // R8 flush
        cur_req = "R8";
        wcsr(8'h08);
        chk(csr_rdata == 8'h00, "R8 flush clears, bit3 0", csr_rdata, 0);
        token();
        chk(tx_zlp == 1 && csr_rdata[2] == 1, "R8 empty after flush", {tx_zlp, csr_rdata[2]}, 3);
        wcsr(8'h00);
        // flush mid-stream
        for (int i = 0; i < 4; i++) load(8'h40 + i);
        wcsr(8'h01);
        token();
        idle(1);
        wcsr(8'h08);
        chk(tx_valid == 0 && csr_rdata == 8'h00, "R8 abort", {tx_valid, csr_rdata}, 0);
        // flush with token same cycle
        load(8'h11);
        wcsr(8'h01);
        csr_we = 1; csr_wdata = 8'h08; tok = 1; @(negedge clk); csr_we = 0; tok = 0;
        chk(tx_zlp == 1 && tx_valid == 0 && csr_rdata[2] == 1, "R8 token+flush", {tx_valid, tx_zlp, csr_rdata[2]}, 3);
        wcsr(8'h00);

        // R10 ready with empty buffer
        cur_req = "R10";
        wcsr(8'h01);
        token();
        chk(tx_zlp == 1 && csr_rdata == 8'h02, "R10 zlp no underrun", {tx_zlp, csr_rdata}, 'h102);
        wcsr(8'h00);

        // R2 full buffer
        cur_req = "R2";
        for (int i = 0; i < DEPTH + 2; i++) load(8'hC0 + i);
        wcsr(8'h01);
        token();
        collect(got);
        chk(got.size() == DEPTH, "R2 capacity", got.size(), DEPTH);
        chk(got[DEPTH-1] == 8'hC0 + DEPTH - 1, "R2 last kept byte", got[DEPTH-1], 8'hC0 + DEPTH - 1);
        idle(2);

        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule